// File: doc/BRIEF.md
# S/PDIF Input Sample-Rate Classifier

This block watches a raw biphase-mark audio input line and works out which sample rate the incoming stream uses. The line is first brought into the fast reference clock domain. The block then times every interval between two signal edges in reference clock cycles, and keeps the narrowest interval seen during a measurement window. The window length is programmable and is normally set to 1 ms.

When a window closes, twice the narrowest width is compared against six programmable thresholds. Each threshold sits between two neighbouring rates. The result is one of seven rate codes (0 = 32 kHz, 1 = 44.1 kHz, 2 = 48 kHz, 3 = 88.2 kHz, 4 = 96 kHz, 5 = 176.4 kHz, 6 = 192 kHz), or code 7 when there is no signal. The narrowest width is reported next to the code. A sticky interrupt flag marks each change of rate code and is gated by a mask. Software sets the window length, the thresholds and the mask through a write-only register port.

Top module: `spdif_rate_classifier`

## Requirements
- R1: A measurement window lasts the number of reference cycles held in the window register (address 0, bits [19:0]). After enable rises, the first window closes on the window-length-th enabled clock edge. `mode_o` and `width_o` change only when a window closes or when enable is low.
- R2: `width_o` is the smallest number of reference cycles between two consecutive input edges, taken over the intervals completed within the closing window. The width saturates at 1023.
- R3: Let D be twice the reported width and T0..T5 the thresholds. The mode is 0 when D >= T0. It is i (1..5) when D < T(i-1) and D >= Ti. It is 6 when D < T5.
- R4: Threshold packing: address 1 holds T0 in bits [29:20], T1 in [19:10] and T2 in [9:0]. Address 2 holds T3, T4 and T5 in the same three slots.
- R5: When no edge-to-edge interval completes within a window, that window reports mode 7 and width 0. A width of 0 always goes with mode 7.
- R6: While `en` is low, the cycle after it is seen low shows mode 7 and width 0, and measuring stops. After reset the outputs are mode 7, width 0, flags 0 and `irq_o` 0.
- R7: Interrupt flag bit 2 is set when a closing window changes the mode code. A change from mode 7 to mode 0 does not set it.
- R8: Flag bits stay set until software writes a one to them at address 4. A set in the same cycle wins over the clear.
- R9: `irq_o` is high exactly when some flag bit is set whose bit in the mask register (address 3, bits [7:0]) is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Measurement enable |
| spdif_in | input | 1 | Raw biphase-mark input line, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 30 | Register write data |
| mode_o | output | 3 | Detected rate code, 7 = no signal |
| width_o | output | 10 | Narrowest edge-to-edge width of the last window |
| irq_flags_o | output | 8 | Sticky interrupt flags |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench uses the default parameters. It programs a 200-cycle window and small thresholds (40, 30, 24, 16, 12, 8), so that input intervals of 3 to 25 cycles cover all seven rate codes within a few windows. It then widens the window to 2000 cycles and drives 1500-cycle intervals, which brings width saturation at 1023 within reach. Threshold values that land exactly on 2×width test the inclusive boundary of the comparison. Rewriting single slots tests the packing order.

// File: rtl/spdif_rc_pkg.sv
package spdif_rc_pkg;
    localparam int ADDR_WINDOW = 0;
    localparam int ADDR_THRESH = 1;
    localparam int ADDR_MASK   = 3;
    localparam int ADDR_CLEAR  = 4;
    localparam int IRQ_MODE_BIT = 2;
endpackage

// File: rtl/rc_edge_sync.sv
module rc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic edge_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.s1   = line_i;
        r_d.s2   = r_q.s1;
        r_d.prev = r_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign edge_o = r_q.s2 ^ r_q.prev;
endmodule

// File: rtl/rc_width_meter.sv
module rc_width_meter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             edge_i,
    input  logic             win_end_i,
    output logic [CNT_W-1:0] min_o,
    output logic             got_o
);
    localparam logic [CNT_W-1:0] SAT = '1;

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic             seen;
        logic [CNT_W-1:0] minw;
        logic             got;
    } meter_t;

    meter_t m_d, m_q;
    logic   take;
    logic   [CNT_W-1:0] eff_min;
    logic   eff_got;

    always_comb begin
        take    = edge_i && m_q.seen;
        eff_min = (take && (!m_q.got || m_q.run < m_q.minw)) ? m_q.run : m_q.minw;
        eff_got = m_q.got || take;

        m_d      = m_q;
        m_d.seen = m_q.seen || edge_i;
        if (edge_i)            m_d.run = CNT_W'(1);
        else if (m_q.run != SAT) m_d.run = m_q.run + CNT_W'(1);
        if (win_end_i) begin
            m_d.minw = SAT;
            m_d.got  = 1'b0;
        end else begin
            m_d.minw = eff_min;
            m_d.got  = eff_got;
        end
        if (!en) begin
            m_d.run  = '0;
            m_d.seen = 1'b0;
            m_d.minw = SAT;
            m_d.got  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '{run: '0, seen: 1'b0, minw: SAT, got: 1'b0};
        else        m_q <= m_d;
    end

    assign min_o = eff_min;
    assign got_o = eff_got;
endmodule

// File: rtl/rc_classifier.sv
module rc_classifier #(
    parameter int NUM_MODES = 7,
    parameter int CNT_W     = 10,
    parameter int MODE_W    = 3
) (
    input  logic [CNT_W-1:0]               width_i,
    input  logic [(NUM_MODES-1)*CNT_W-1:0] th_i,
    output logic [MODE_W-1:0]              mode_o
);
    localparam int NUM_TH = NUM_MODES - 1;

    logic [CNT_W:0] dbl;

    always_comb begin
        dbl    = {width_i, 1'b0};
        mode_o = MODE_W'(NUM_MODES - 1);
        for (int i = NUM_TH - 1; i >= 0; i--) begin
            if (dbl >= {1'b0, th_i[i*CNT_W +: CNT_W]}) mode_o = MODE_W'(i);
        end
    end
endmodule

// File: rtl/spdif_rate_classifier.sv
module spdif_rate_classifier #(
    parameter int BASE_W     = 20,
    parameter int CNT_W      = 10,
    parameter int NUM_MODES  = 7,
    parameter int TH_PER_REG = 3,
    parameter int IRQ_W      = 8,
    parameter int ADDR_W     = 3,
    parameter logic [BASE_W-1:0] RESET_WINDOW = 20'd333333,
    localparam int WORD_W    = TH_PER_REG * CNT_W,
    localparam int MODE_W    = $clog2(NUM_MODES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              spdif_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [MODE_W-1:0] mode_o,
    output logic [CNT_W-1:0]  width_o,
    output logic [IRQ_W-1:0]  irq_flags_o,
    output logic              irq_o
);
    import spdif_rc_pkg::*;

    localparam int NUM_TH = NUM_MODES - 1;
    localparam logic [MODE_W-1:0] MODE_NONE = MODE_W'(NUM_MODES);

    typedef struct packed {
        logic [BASE_W-1:0]       window;
        logic [NUM_TH*CNT_W-1:0] th;
        logic [IRQ_W-1:0]        mask;
        logic [IRQ_W-1:0]        flags;
        logic [MODE_W-1:0]       mode;
        logic [CNT_W-1:0]        width;
        logic [BASE_W-1:0]       cnt;
    } state_t;

    state_t s_d, s_q;
    logic   edge_hit;
    logic   win_end;
    logic   got;
    logic   [CNT_W-1:0]  min_w;
    logic   [MODE_W-1:0] cls_mode;
    logic   [MODE_W-1:0] new_mode;

    rc_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (spdif_in),
        .edge_o (edge_hit)
    );

    rc_width_meter #(.CNT_W(CNT_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .edge_i    (edge_hit),
        .win_end_i (win_end),
        .min_o     (min_w),
        .got_o     (got)
    );

    rc_classifier #(.NUM_MODES(NUM_MODES), .CNT_W(CNT_W), .MODE_W(MODE_W)) u_cls (
        .width_i (min_w),
        .th_i    (s_q.th),
        .mode_o  (cls_mode)
    );

    assign win_end  = en && (s_q.cnt >= s_q.window - BASE_W'(1));
    assign new_mode = got ? cls_mode : MODE_NONE;

    always_comb begin
        s_d = s_q;

        if (wr_en && wr_addr == ADDR_W'(ADDR_WINDOW)) s_d.window = wr_data[BASE_W-1:0];
        if (wr_en && wr_addr == ADDR_W'(ADDR_MASK))   s_d.mask   = wr_data[IRQ_W-1:0];
        for (int i = 0; i < NUM_TH; i++) begin
            if (wr_en && wr_addr == ADDR_W'(ADDR_THRESH + i / TH_PER_REG))
                s_d.th[i*CNT_W +: CNT_W] =
                    wr_data[CNT_W*(TH_PER_REG - 1 - i % TH_PER_REG) +: CNT_W];
        end
        if (wr_en && wr_addr == ADDR_W'(ADDR_CLEAR))
            s_d.flags = s_q.flags & ~wr_data[IRQ_W-1:0];

        if (!en) begin
            s_d.cnt   = '0;
            s_d.mode  = MODE_NONE;
            s_d.width = '0;
        end else if (win_end) begin
            s_d.cnt   = '0;
            s_d.mode  = new_mode;
            s_d.width = got ? min_w : '0;
            if (new_mode != s_q.mode && !(s_q.mode == MODE_NONE && new_mode == '0))
                s_d.flags[IRQ_MODE_BIT] = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + BASE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.window <= RESET_WINDOW;
            s_q.mode   <= MODE_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o      = s_q.mode;
    assign width_o     = s_q.width;
    assign irq_flags_o = s_q.flags;
    assign irq_o       = |(s_q.flags & s_q.mask);
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
    parameter int ADDR_W = 3,
    parameter int WORD_W = 30,
    parameter int MODE_W = 3,
    parameter int CNT_W  = 10,
    parameter int IRQ_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic [MODE_W-1:0] mode_o,
    input logic [CNT_W-1:0]  width_o,
    input logic [IRQ_W-1:0]  irq_flags_o,
    input logic              irq_o,
    input logic              win_end
);
    logic clr_bit2;
    assign clr_bit2 = wr_en && wr_addr == ADDR_W'(4) && wr_data[2];

    AST_MODE_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != $past(mode_o)) |-> ($past(win_end) || !$past(en))); // R1

    AST_WIDTH_ZERO_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (width_o == '0) == (mode_o == MODE_W'(7))); // R5

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (mode_o == MODE_W'(7) && width_o == '0)); // R6

    AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flags_o[2]) |-> (mode_o != $past(mode_o)) &&
            !($past(mode_o) == MODE_W'(7) && mode_o == '0)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags_o[2] && !clr_bit2) |=> irq_flags_o[2]); // R8

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_flags_o != '0)); // R9
endmodule

bind spdif_rate_classifier rc_checker #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .MODE_W(MODE_W), .CNT_W(CNT_W), .IRQ_W(IRQ_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .mode_o      (mode_o),
    .width_o     (width_o),
    .irq_flags_o (irq_flags_o),
    .irq_o       (irq_o),
    .win_end     (win_end)
);

// File: tb/sim_spdif_rate_classifier.sv
`timescale 1ns/1ps
module sim_spdif_rate_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        spdif_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [29:0] wr_data = '0;
    logic [2:0]  mode_o;
    logic [9:0]  width_o;
    logic [7:0]  irq_flags_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    int wa = 0;
    int wb = 0;
    int win = 200;
    bit done = 0;

    typedef struct {
        int    mode;
        int    width;
        string tag;
    } exp_t;
    exp_t q[$];
    event go;

    always #2.5 clk = ~clk;

    spdif_rate_classifier u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .spdif_in(spdif_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode_o(mode_o), .width_o(width_o),
        .irq_flags_o(irq_flags_o), .irq_o(irq_o)
    );

    initial begin
        forever begin
            if (wa == 0) @(negedge clk);
            else begin
                repeat (wa) @(negedge clk);
                spdif_in = ~spdif_in;
                repeat (wb) @(negedge clk);
                spdif_in = ~spdif_in;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(go);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " mode"}, int'(mode_o), e.mode);
                chk({e.tag, " width"}, int'(width_o), e.width);
            end
        end
    end

    task automatic wr(int addr, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 30'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_case(int a, int b, int nwin, int m, int w, string tag);
        exp_t e;
        wa = a; wb = b;
        repeat (nwin * win) @(negedge clk);
        e.mode = m; e.width = w; e.tag = tag;
        q.push_back(e);
        -> go;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset mode", int'(mode_o), 7);
        chk("R6 reset width", int'(width_o), 0);
        chk("R6 reset flags", int'(irq_flags_o), 0);
        chk("R6 reset irq", int'(irq_o), 0);

        wr(0, win);
        wr(1, (40 << 20) | (30 << 10) | 24);
        wr(2, (16 << 20) | (12 << 10) | 8);
        en = 1'b1;

        run_case(25, 25, 3, 0, 25, "R3 mode0");
        chk("R7 no irq 7->0", int'(irq_flags_o), 0);
        run_case(17, 17, 3, 1, 17, "R3 mode1");
        chk("R7 irq on change", int'(irq_flags_o), 4);
        chk("R9 masked off", int'(irq_o), 0);
        wr(3, 8'h04);
        @(negedge clk);
        chk("R9 mask on", int'(irq_o), 1);
        repeat (2 * win) @(negedge clk);
        chk("R8 sticky", int'(irq_flags_o), 4);
        wr(4, 8'h04);
        @(negedge clk);
        chk("R8 w1c clear", int'(irq_flags_o), 0);
        chk("R9 irq after clear", int'(irq_o), 0);

        run_case(13, 13, 3, 2, 13, "R3 mode2");
        run_case(9, 9, 3, 3, 9, "R3 mode3");
        run_case(7, 7, 3, 4, 7, "R3 mode4");
        run_case(5, 5, 3, 5, 5, "R3 mode5");
        run_case(3, 3, 3, 6, 3, "R3 mode6");
        run_case(20, 20, 3, 0, 20, "R3 boundary equal");
        run_case(19, 19, 3, 1, 19, "R3 boundary below");

        wr(1, (51 << 20) | (30 << 10) | 24);
        run_case(25, 25, 3, 1, 25, "R4 slot T0");
        wr(1, (40 << 20) | (30 << 10) | 24);
        wr(2, (16 << 20) | (15 << 10) | 11);
        run_case(7, 7, 3, 5, 7, "R4 slot T4");
        run_case(5, 5, 3, 6, 5, "R4 slot T5");
        wr(2, (16 << 20) | (12 << 10) | 8);

        run_case(9, 18, 3, 3, 9, "R2 min of mixed");
        wr(4, 8'hFF);
        run_case(0, 0, 3, 7, 0, "R5 no signal");
        chk("R7 irq to none", int'(irq_flags_o), 4);
        wr(4, 8'hFF);
        run_case(9, 9, 3, 3, 9, "R7 from none");
        chk("R7 irq 7->3", int'(irq_flags_o), 4);

        en = 1'b0;
        @(negedge clk);
        chk("R6 disable mode", int'(mode_o), 7);
        chk("R6 disable width", int'(width_o), 0);
        repeat (2 * win) @(negedge clk);
        chk("R6 held off", int'(mode_o), 7);

        en = 1'b1;
        repeat (win - 1) @(negedge clk);
        chk("R1 before window end", int'(mode_o), 7);
        @(negedge clk);
        chk("R1 at window end", int'(mode_o), 3);

        win = 2000;
        wr(0, win);
        run_case(1500, 1500, 4, 0, 1023, "R2 saturation");

        finish_run();
    end
endmodule